// File: doc/BRIEF.md
# Trace Buffer Throttle Controller

This block sits beside two trace buffers, one holding instruction trace and one holding data trace, and reacts when either of them runs short of room. From the free-space count of each buffer and one programmable level it works out three things. The first is a stall request back to the processor. The second is whether the data-trace packet being offered right now should be dropped, according to whether it comes from a load or a store. The third is whether instruction trace should win arbitration over data trace.

Software sets the policy through one 32-bit control register, written and read over a simple register port. A 2-bit level code picks the free-space limit as 0, 1/4, 1/2 or 3/4 of each buffer's depth. A buffer counts as "low" while its free space is strictly below that limit, so code 0 never triggers anything and code 3 intrudes the most. The stall output is registered. The drop and priority outputs are combinational, so a packet can be discarded in the same cycle it is presented.

Top module: `trace_throttle_ctrl`

## Requirements
- R1: Control fields sit at fixed bit positions and read back as written: level code [3:2], instruction-stall enable [8], data-stall enable [9], instruction-priority enable [10], discard select [12:11]; `reg_rd_data` shows the register with no delay after the write edge.
- R2: Bits [31:13], [7:4] and [1:0] always read as zero, and writing ones to them changes nothing.
- R3: Synchronous active-high reset clears the register to zero, and afterwards stall, drop and priority are all low.
- R4: The limit for level code c is (depth*c)/4 with integer division, computed per buffer; a buffer is low when its free count is strictly less than the limit; code 0 never makes a buffer low.
- R5: With the instruction-stall enable set, `cpu_stall` is high on the clock after one in which the instruction buffer was low.
- R6: With the data-stall enable set, `cpu_stall` is high on the clock after one in which the data buffer was low.
- R7: `cpu_stall` is the registered OR of the two enabled conditions, and is low whenever neither enabled condition held in the previous cycle.
- R8: `pkt_drop` is combinational. With `pkt_valid` high and the data buffer low, it goes high for discard select 01 on a load (`pkt_is_store`=0), for 10 on a store (`pkt_is_store`=1) and for 11 on either; select 00 never drops.
- R9: `inst_prio` is high exactly when the priority enable is set and the instruction buffer is low.
- R10: `pkt_drop` is low whenever `pkt_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Write strobe for the control register |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Current register contents, reserved bits zero |
| ibuf_free | input | IBUF_CNT_W | Free entries in the instruction trace buffer |
| dbuf_free | input | DBUF_CNT_W | Free entries in the data trace buffer |
| pkt_valid | input | 1 | A data-trace packet is offered this cycle |
| pkt_is_store | input | 1 | Packet type: 0 load, 1 store |
| cpu_stall | output | 1 | Registered stall request to the processor |
| pkt_drop | output | 1 | Drop the offered data packet |
| inst_prio | output | 1 | Give instruction trace arbitration priority |

## Verification
The assertions take the free-space counts to be at most the configured depth of each buffer, and the type tag to matter only while `pkt_valid` is high. The stimulus draws free counts from 0 up to the depth, with extra weight just below, at and just above each limit. It offers packets of both types with the strobe toggling. The stall checks depend on register writes and free-count changes landing exactly one edge before the stall is sampled, so inputs change only on the falling edge.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int REG_W = 32;

  // bit positions software depends on
  localparam int LVL_LSB  = 2;
  localparam int ISTL_BIT = 8;
  localparam int DSTL_BIT = 9;
  localparam int PRIO_BIT = 10;
  localparam int DISC_LSB = 11;

  localparam logic [REG_W-1:0] WR_MASK = 32'h0000_1F0C;

  typedef struct packed {
    logic [1:0] discard;  // bit0: loads, bit1: stores
    logic       prio_en;
    logic       dstall_en;
    logic       istall_en;
    logic [1:0] level;
  } tt_ctrl_t;
endpackage

// File: rtl/tt_ctrl_reg.sv
module tt_ctrl_reg
  import tt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output tt_ctrl_t         ctrl,
  output logic [REG_W-1:0] rd_data
);
  tt_ctrl_t ctrl_q;
  logic     unused_rsvd;

  assign unused_rsvd = ^{wr_data[31:13], wr_data[7:4], wr_data[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q.level     <= wr_data[LVL_LSB +: 2];
      ctrl_q.istall_en <= wr_data[ISTL_BIT];
      ctrl_q.dstall_en <= wr_data[DSTL_BIT];
      ctrl_q.prio_en   <= wr_data[PRIO_BIT];
      ctrl_q.discard   <= wr_data[DISC_LSB +: 2];
    end
  end

  always_comb begin
    rd_data                   = '0;
    rd_data[LVL_LSB +: 2]     = ctrl_q.level;
    rd_data[ISTL_BIT]         = ctrl_q.istall_en;
    rd_data[DSTL_BIT]         = ctrl_q.dstall_en;
    rd_data[PRIO_BIT]         = ctrl_q.prio_en;
    rd_data[DISC_LSB +: 2]    = ctrl_q.discard;
  end

  assign ctrl = ctrl_q;

  // R2: reserved positions never show a one
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~WR_MASK) == '0);

  // R1: a write lands in the register on the next edge
  p_write_lands_r1: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_data == ($past(wr_data) & WR_MASK));
endmodule

// File: rtl/tt_level_cmp.sv
module tt_level_cmp #(
  parameter int DEPTH = 256,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [1:0]       level,
  input  logic [CNT_W-1:0] free_cnt,
  output logic             below
);
  localparam int LIM1 = (DEPTH * 1) / 4;
  localparam int LIM2 = (DEPTH * 2) / 4;
  localparam int LIM3 = (DEPTH * 3) / 4;

  logic [CNT_W-1:0] limit;

  always_comb begin
    unique case (level)
      2'd1:    limit = CNT_W'(LIM1);
      2'd2:    limit = CNT_W'(LIM2);
      2'd3:    limit = CNT_W'(LIM3);
      default: limit = '0;
    endcase
  end

  assign below = free_cnt < limit;
endmodule

// File: rtl/tt_policy.sv
module tt_policy
  import tt_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  tt_ctrl_t ctrl,
  input  logic     ilow,
  input  logic     dlow,
  input  logic     pkt_valid,
  input  logic     pkt_is_store,
  output logic     stall,
  output logic     drop,
  output logic     prio
);
  logic stall_q;
  logic type_sel;

  always_ff @(posedge clk) begin
    if (rst) stall_q <= 1'b0;
    else     stall_q <= (ctrl.istall_en & ilow) | (ctrl.dstall_en & dlow);
  end

  assign type_sel = pkt_is_store ? ctrl.discard[1] : ctrl.discard[0];
  assign drop     = pkt_valid & dlow & type_sel;
  assign prio     = ctrl.prio_en & ilow;
  assign stall    = stall_q;

  // R7: a stall needs some enable from the previous cycle
  p_stall_needs_en_r7: assert property (@(posedge clk) disable iff (rst)
    stall |-> $past(ctrl.istall_en | ctrl.dstall_en));

  // R5/R6: a stall needs a low buffer in the previous cycle
  p_stall_needs_low_r5: assert property (@(posedge clk) disable iff (rst)
    stall |-> $past(ilow | dlow));

  // R10: no drop without a packet
  p_drop_needs_valid_r10: assert property (@(posedge clk) disable iff (rst)
    drop |-> pkt_valid);

  // R8: no drop with select 00 or a roomy data buffer
  p_drop_needs_sel_r8: assert property (@(posedge clk) disable iff (rst)
    drop |-> (ctrl.discard != 2'b00) && dlow);

  // R9: priority only with its enable
  p_prio_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
    prio |-> ctrl.prio_en);

  // R4: level code 0 keeps every combinational policy quiet
  p_level0_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (ctrl.level == 2'b00) |-> !drop && !prio && !ilow && !dlow);
endmodule

// File: rtl/trace_throttle_ctrl.sv
module trace_throttle_ctrl
  import tt_pkg::*;
#(
  parameter int IBUF_DEPTH = 256,
  parameter int DBUF_DEPTH = 256,
  parameter int IBUF_CNT_W = $clog2(IBUF_DEPTH + 1),
  parameter int DBUF_CNT_W = $clog2(DBUF_DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr_en,
  input  logic [31:0]           reg_wr_data,
  output logic [31:0]           reg_rd_data,
  input  logic [IBUF_CNT_W-1:0] ibuf_free,
  input  logic [DBUF_CNT_W-1:0] dbuf_free,
  input  logic                  pkt_valid,
  input  logic                  pkt_is_store,
  output logic                  cpu_stall,
  output logic                  pkt_drop,
  output logic                  inst_prio
);
  tt_ctrl_t ctrl;
  logic     ilow;
  logic     dlow;

  tt_ctrl_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr_en),
    .wr_data (reg_wr_data),
    .ctrl    (ctrl),
    .rd_data (reg_rd_data)
  );

  tt_level_cmp #(.DEPTH(IBUF_DEPTH), .CNT_W(IBUF_CNT_W)) u_icmp (
    .level    (ctrl.level),
    .free_cnt (ibuf_free),
    .below    (ilow)
  );

  tt_level_cmp #(.DEPTH(DBUF_DEPTH), .CNT_W(DBUF_CNT_W)) u_dcmp (
    .level    (ctrl.level),
    .free_cnt (dbuf_free),
    .below    (dlow)
  );

  tt_policy u_pol (
    .clk          (clk),
    .rst          (rst),
    .ctrl         (ctrl),
    .ilow         (ilow),
    .dlow         (dlow),
    .pkt_valid    (pkt_valid),
    .pkt_is_store (pkt_is_store),
    .stall        (cpu_stall),
    .drop         (pkt_drop),
    .prio         (inst_prio)
  );

  // R3: quiet outputs in the cycle after reset
  p_reset_quiet_r3: assert property (@(posedge clk)
    $past(rst) |-> !cpu_stall && reg_rd_data == '0);
endmodule

// File: tb/trace_throttle_ctrl_tb_top.sv
`timescale 1ns/1ps
module trace_throttle_ctrl_tb_top;
  localparam int ID = 256;
  localparam int DD = 256;
  localparam int IW = $clog2(ID + 1);
  localparam int DW = $clog2(DD + 1);
  localparam logic [31:0] MASK = 32'h0000_1F0C;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr_en = 1'b0;
  logic [31:0]   reg_wr_data = '0;
  logic [31:0]   reg_rd_data;
  logic [IW-1:0] ibuf_free = '0;
  logic [DW-1:0] dbuf_free = '0;
  logic          pkt_valid = 1'b0;
  logic          pkt_is_store = 1'b0;
  logic          cpu_stall, pkt_drop, inst_prio;

  int total = 0;
  int bad   = 0;

  // reference state
  logic [31:0] m_reg   = '0;
  logic        m_stall = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  trace_throttle_ctrl #(.IBUF_DEPTH(ID), .DBUF_DEPTH(DD)) dut_i (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
    .ibuf_free(ibuf_free), .dbuf_free(dbuf_free),
    .pkt_valid(pkt_valid), .pkt_is_store(pkt_is_store),
    .cpu_stall(cpu_stall), .pkt_drop(pkt_drop), .inst_prio(inst_prio)
  );

  function automatic int lim(input int depth, input logic [1:0] code);
    return (depth * int'(code)) / 4;
  endfunction

  function automatic bit low_i(input logic [31:0] r, input int f);
    return f < lim(ID, r[3:2]);
  endfunction

  function automatic bit low_d(input logic [31:0] r, input int f);
    return f < lim(DD, r[3:2]);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_reg   <= '0;
      m_stall <= 1'b0;
    end else begin
      m_stall <= (m_reg[8] && low_i(m_reg, int'(ibuf_free))) ||
                 (m_reg[9] && low_d(m_reg, int'(dbuf_free)));
      if (reg_wr_en) m_reg <= reg_wr_data & MASK;
    end
  end

  task automatic chk(input string req, input string nm, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, nm, act, exp);
    end
  endtask

  // compare all outputs against the model, then drive the next inputs
  task automatic compare_all();
    bit dl, il, ed, ep;
    dl = low_d(m_reg, int'(dbuf_free));
    il = low_i(m_reg, int'(ibuf_free));
    ed = pkt_valid && dl && (pkt_is_store ? m_reg[12] : m_reg[11]);
    ep = m_reg[10] && il;
    chk("R1", "reg_rd_data", reg_rd_data, m_reg);
    chk("R2", "reserved", reg_rd_data & ~MASK, 32'h0);
    chk("R5/R6/R7", "cpu_stall", 32'(cpu_stall), 32'(m_stall));
    chk("R8", "pkt_drop", 32'(pkt_drop), 32'(ed));
    chk("R9", "inst_prio", 32'(inst_prio), 32'(ep));
    if (!pkt_valid) chk("R10", "pkt_drop idle", 32'(pkt_drop), 32'h0);
    if (m_reg[3:2] == 2'b00)
      chk("R4", "level0 quiet", {30'h0, pkt_drop, inst_prio}, 32'h0);
  endtask

  task automatic step(input bit we, input logic [31:0] wd, input int fi, input int fd,
                      input bit v, input bit st);
    @(negedge clk);
    compare_all();
    reg_wr_en    = we;
    reg_wr_data  = wd;
    ibuf_free    = IW'(fi);
    dbuf_free    = DW'(fd);
    pkt_valid    = v;
    pkt_is_store = st;
  endtask

  function automatic int near(input int depth, input logic [1:0] code);
    int b;
    b = lim(depth, code) + int'($urandom_range(0, 2)) - 1;
    if (b < 0) b = 0;
    if (b > depth) b = depth;
    return b;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R3: reset state while reset is held
    chk("R3", "stall in reset", 32'(cpu_stall), 32'h0);
    chk("R3", "rd in reset", reg_rd_data, 32'h0);
    rst = 1'b0;
    // R3: no policy right after reset even with empty buffers
    step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 0, 0);
    chk("R3", "quiet after reset", {29'h0, cpu_stall, pkt_drop, inst_prio}, 32'h0);
    // R2: write all ones, then read back only the fields
    step(1, 32'hFFFF_FFFF, 10, 10, 0, 0);
    step(0, 0, 10, 10, 0, 0);
    chk("R2", "all ones readback", reg_rd_data, MASK);
    // directed: each level, boundary free counts, each single enable
    for (int c = 0; c < 4; c++) begin
      for (int e = 0; e < 8; e++) begin
        logic [31:0] w;
        w = (32'(c) << 2) | (32'(e & 1) << 8) | (32'((e >> 1) & 1) << 9) |
            (32'((e >> 2) & 1) << 10) | (32'(e & 3) << 11) | 32'hFFFF_E0F3;
        step(1, w, ID, DD, 0, 0);
        for (int k = -1; k <= 1; k++) begin
          int fi, fd;
          fi = lim(ID, 2'(c)) + k; if (fi < 0) fi = 0;
          fd = lim(DD, 2'(c)) + k; if (fd < 0) fd = 0;
          step(0, 0, fi, DD, 1, 0);   // R5: instruction side only
          step(0, 0, ID, fd, 1, 1);   // R6: data side only
          step(0, 0, fi, fd, 1, 0);   // R7: both
          step(0, 0, fi, fd, 0, 1);   // R10
        end
      end
    end
    // random sweep
    for (int n = 0; n < 3000; n++) begin
      bit we;
      logic [1:0] c;
      we = ($urandom_range(0, 15) == 0);
      c  = we ? reg_wr_data[3:2] : m_reg[3:2];
      step(we, $urandom, ($urandom_range(0, 1) != 0) ? near(ID, c) : int'($urandom_range(0, ID)),
           ($urandom_range(0, 1) != 0) ? near(DD, c) : int'($urandom_range(0, DD)),
           $urandom_range(0, 1) != 0, $urandom_range(0, 1) != 0);
    end
    step(0, 0, ID, DD, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule